// File: doc/BRIEF.md
# Edge-Selectable Pulse Capture Timer

This block times one asynchronous digital input against a free-running reference clock. The input is brought into the clock domain by a two-flop synchronizer, and its rising and falling transitions are detected by comparing consecutive synchronized samples. A counter starts on a selectable start transition and stops on the next selectable stop transition. The count is then written to a result register and flagged to the host as a fresh value.

The start and stop polarities are set independently. Rising-to-falling gives the width of a high pulse and falling-to-rising the width of a low pulse. Matching polarities give the period between rising edges or between falling edges. In the matching-polarity modes, each stop transition also starts the next interval, so consecutive periods are captured with no gap between them. The host reads results through a simple read strobe that acknowledges the sticky flags. It can derive duty cycle from a width and a period. The counter is 32 bits wide by default. At a 33 MHz reference, one count is about 30.3 ns and the longest interval is about 130 s.

An interval longer than the counter can hold is abandoned. In that case the result register is not touched, and a sticky overflow flag is raised instead.

Top module: `pulse_capture_timer`

## Requirements
- R1: After a synchronous active-low reset, `result_q` is zero and `result_vld`, `fresh`, `overrun` and `overflow` are all low.
- R2: `start_rise` and `stop_rise` select the start and stop transition polarities independently, with 1 meaning low-to-high and 0 meaning high-to-low. The modes report as follows: 1/0 reports high width, 0/1 reports low width, 1/1 reports the rising-to-rising period, and 0/0 reports the falling-to-falling period.
- R3: The captured value is the number of reference clock cycles between the start transition and the stop transition. An input level held for N cycles (N >= 2) is therefore reported as N.
- R4: When the start and stop polarities match, the stop transition of one interval is the start of the next, so every period in a train is reported.
- R5: `result_vld` is high for exactly one cycle, beginning at the third rising clock edge after the stop transition of the input. `result_q` takes the new value on that same edge.
- R6: `fresh` is set by every capture and cleared by a cycle with `rd_strobe` high. A capture in the same cycle as the strobe leaves it set.
- R7: `overrun` is set when a capture arrives while `fresh` is still set and no `rd_strobe` is applied. It is cleared by `rd_strobe`.
- R8: If an interval exceeds 2^CNT_W-1 cycles, the measurement is abandoned, `result_q` keeps its old value and the sticky `overflow` flag is set; `rd_strobe` clears it. An interval of exactly 2^CNT_W-1 cycles is captured normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sig_in | input | 1 | Asynchronous input being timed |
| start_rise | input | 1 | Start polarity: 1 rising, 0 falling |
| stop_rise | input | 1 | Stop polarity: 1 rising, 0 falling |
| rd_strobe | input | 1 | Host read acknowledge, clears sticky flags |
| result_q | output | CNT_W (32) | Last captured interval in clock cycles |
| result_vld | output | 1 | One-cycle strobe marking a new capture |
| fresh | output | 1 | Sticky: unread result present |
| overrun | output | 1 | Sticky: a result was replaced before being read |
| overflow | output | 1 | Sticky: an interval exceeded the counter range |

## Verification
An input transition takes three rising edges to appear as a capture: two synchronizer stages, then the edge-qualified capture register. The bench therefore drives the input only on falling clock edges. The latency check then samples `result_vld` just after the second edge, where it must be low, and just after the third edge, where it must be high. All other results are compared when the strobe is seen at a falling edge, in the order the bench predicted them from the segment lengths it generated. The sticky flags are examined only after a trailing low stretch of ten cycles, well past the three-edge latency.

// File: rtl/pcap_pkg.sv
// Package: shared types and helpers for the pulse capture timer.
// Assumes nothing beyond a single clock domain for all users.
package pcap_pkg;

    // Polarity encoding of a selected transition.
    typedef enum logic {
        POL_FALL = 1'b0,
        POL_RISE = 1'b1
    } pol_e;

    // Picks the detected edge that matches a polarity selection.
    function automatic logic pick_edge(input pol_e pol, input logic rise, input logic fall);
        return (pol == POL_RISE) ? rise : fall;
    endfunction

endpackage

// File: rtl/pcap_edge_det.sv
// Module: pcap_edge_det
// Synchronizes an asynchronous input through SYNC_STAGES flops and flags
// rising and falling transitions by comparing the last synchronized sample
// with the one before it. Assumes the input is glitch-free relative to the
// clock period; a level must be held at least one cycle to be seen.
module pcap_edge_det #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise,
    output logic fall
);

    localparam int PIPE_W = SYNC_STAGES + 1;

    logic [PIPE_W-1:0] pipe;
    logic              cur;
    logic              prev;

    // Shift the input through the synchronizer plus one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe <= '0;
        end else begin
            pipe <= {pipe[PIPE_W-2:0], din};
        end
    end

    assign cur  = pipe[SYNC_STAGES-1];
    assign prev = pipe[SYNC_STAGES];

    // Transition flags from the two most recent synchronized samples.
    always_comb begin
        rise = cur & ~prev;
        fall = ~cur & prev;
    end

endmodule

// File: rtl/pcap_interval_cnt.sv
// Module: pcap_interval_cnt
// Interval counter. It waits for the start edge, then counts reference cycles
// until the stop edge, at which it presents the count for capture. With
// matching polarities the stop edge restarts counting at once. If the count
// reaches its maximum with no stop edge, the measurement is abandoned and an
// overflow event is raised. Assumes the polarity selects are changed only
// while idle or under reset.
module pcap_interval_cnt
    import pcap_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise,
    input  logic             fall,
    input  logic             start_rise,
    input  logic             stop_rise,
    output logic             cap_evt,
    output logic [CNT_W-1:0] cap_val,
    output logic             ovf_evt
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic             busy;
    logic [CNT_W-1:0] cnt;
    logic             start_hit;
    logic             stop_hit;
    logic             chained;

    // Decode the selected start and stop edges.
    always_comb begin
        start_hit = pick_edge(pol_e'(start_rise), rise, fall);
        stop_hit  = pick_edge(pol_e'(stop_rise), rise, fall);
        chained   = (start_rise == stop_rise);
    end

    // Events presented to the result register.
    always_comb begin
        cap_evt = busy & stop_hit;
        cap_val = cnt;
        ovf_evt = busy & ~stop_hit & (cnt == CNT_MAX);
    end

    // Counting state: idle, counting, restart, or abandon.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (busy) begin
            if (stop_hit) begin
                busy <= chained;
                cnt  <= chained ? CNT_ONE : '0;
            end else if (cnt == CNT_MAX) begin
                busy <= 1'b0;
                cnt  <= '0;
            end else begin
                cnt <= cnt + CNT_ONE;
            end
        end else if (start_hit) begin
            busy <= 1'b1;
            cnt  <= CNT_ONE;
        end
    end

    // R3: a running count advances by one each cycle with no stop edge.
    a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !stop_hit && cnt != CNT_MAX) |=> (cnt == $past(cnt) + CNT_ONE));

    // R4: with matching polarities a capture leaves the counter running.
    a_r4_chain_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_evt && chained) |=> (busy && cnt == CNT_ONE));

    // R8: an abandoned interval never coincides with a capture.
    a_r8_ovf_excl: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> !busy);

endmodule

// File: rtl/pcap_result_reg.sv
// Module: pcap_result_reg
// Host-facing result register. It latches each captured count, raises a
// one-cycle valid strobe and keeps the sticky fresh, overrun and overflow
// flags. A read strobe acknowledges all three flags. Assumes capture and
// overflow events never occur in the same cycle.
module pcap_result_reg #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_evt,
    input  logic [CNT_W-1:0] cap_val,
    input  logic             ovf_evt,
    input  logic             rd,
    output logic [CNT_W-1:0] result_q,
    output logic             result_vld,
    output logic             fresh,
    output logic             overrun,
    output logic             overflow
);

    // Latch results and maintain the sticky status bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q   <= '0;
            result_vld <= 1'b0;
            fresh      <= 1'b0;
            overrun    <= 1'b0;
            overflow   <= 1'b0;
        end else begin
            result_vld <= cap_evt;
            if (cap_evt) begin
                result_q <= cap_val;
            end
            fresh    <= cap_evt | (fresh & ~rd);
            overrun  <= (cap_evt & fresh & ~rd) | (overrun & ~rd);
            overflow <= ovf_evt | (overflow & ~rd);
        end
    end

    // R5: the valid strobe never lasts two cycles.
    a_r5_vld_single: assert property (@(posedge clk) disable iff (!rst_n)
        result_vld |=> !result_vld);

    // R6: a new result is always marked unread.
    a_r6_vld_fresh: assert property (@(posedge clk) disable iff (!rst_n)
        result_vld |-> fresh);

    // R6: fresh stays set until acknowledged.
    a_r6_fresh_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (fresh && !rd) |=> fresh);

    // R8: the result holds whenever no capture is signalled.
    a_r8_result_kept: assert property (@(posedge clk) disable iff (!rst_n)
        !result_vld |-> $stable(result_q));

    // R8: overflow stays set until acknowledged.
    a_r8_ovf_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !rd) |=> overflow);

endmodule

// File: rtl/pulse_capture_timer.sv
// Module: pulse_capture_timer
// Top level of the edge-selectable pulse capture timer. It chains the input
// synchronizer and edge detector, the interval counter and the host result
// register. Assumes one reference clock and that the polarity selects are
// changed only under reset or while no interval is running.
module pulse_capture_timer #(
    parameter int CNT_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sig_in,
    input  logic             start_rise,
    input  logic             stop_rise,
    input  logic             rd_strobe,
    output logic [CNT_W-1:0] result_q,
    output logic             result_vld,
    output logic             fresh,
    output logic             overrun,
    output logic             overflow
);

    logic             rise;
    logic             fall;
    logic             cap_evt;
    logic [CNT_W-1:0] cap_val;
    logic             ovf_evt;

    pcap_edge_det #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_edge (
        .clk (clk),
        .rst_n(rst_n),
        .din (sig_in),
        .rise(rise),
        .fall(fall)
    );

    pcap_interval_cnt #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise      (rise),
        .fall      (fall),
        .start_rise(start_rise),
        .stop_rise (stop_rise),
        .cap_evt   (cap_evt),
        .cap_val   (cap_val),
        .ovf_evt   (ovf_evt)
    );

    pcap_result_reg #(
        .CNT_W(CNT_W)
    ) u_res (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_evt   (cap_evt),
        .cap_val   (cap_val),
        .ovf_evt   (ovf_evt),
        .rd        (rd_strobe),
        .result_q  (result_q),
        .result_vld(result_vld),
        .fresh     (fresh),
        .overrun   (overrun),
        .overflow  (overflow)
    );

endmodule

// File: tb/sim_pulse_capture_timer.sv
`timescale 1ns/1ps
module sim_pulse_capture_timer;

    localparam int CLK_PERIOD = 30;
    localparam int CW         = 8;
    localparam int CMAX       = (1 << CW) - 1;
    localparam int NSEG       = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sig_in = 1'b0;
    logic          start_rise = 1'b1;
    logic          stop_rise = 1'b0;
    logic          rd_strobe = 1'b0;
    logic [CW-1:0] result_q;
    logic          result_vld;
    logic          fresh;
    logic          overrun;
    logic          overflow;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  mon_en = 1'b0;
    int  exp_q[$];
    string mon_tag = "R2";

    pulse_capture_timer #(.CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .sig_in(sig_in),
        .start_rise(start_rise), .stop_rise(stop_rise), .rd_strobe(rd_strobe),
        .result_q(result_q), .result_vld(result_vld), .fresh(fresh),
        .overrun(overrun), .overflow(overflow)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(CLK_PERIOD * 150000);
        chk(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    // Compare each valid strobe with the next predicted result.
    always @(negedge clk) begin
        if (mon_en && result_vld) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, mon_tag, int'(result_q), -1);
            end else begin
                int e;
                e = exp_q.pop_front();
                chk(int'(result_q) == e, mon_tag, int'(result_q), e);
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        sig_in = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Hold the input at lvl for n cycles, changing on a falling clock edge.
    task automatic seg(input bit lvl, input int n);
        @(negedge clk);
        sig_in = lvl;
        repeat (n - 1) @(negedge clk);
    endtask

    task automatic rd_pulse();
        @(negedge clk);
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
    endtask

    // Random pulse train in one mode; expectations derived from segment lengths.
    task automatic rand_train(input bit s_r, input bit p_r, input string tag);
        int h[NSEG + 1];
        int l[NSEG];
        start_rise = s_r;
        stop_rise  = p_r;
        do_reset();
        for (int i = 0; i < NSEG; i++) begin
            h[i] = 2 + int'($urandom_range(38));
            l[i] = 2 + int'($urandom_range(38));
        end
        h[NSEG] = 5;
        for (int i = 0; i < NSEG; i++) begin
            if (s_r && !p_r) exp_q.push_back(h[i]);
            if (!s_r && p_r) exp_q.push_back(l[i]);
            if (s_r && p_r) exp_q.push_back(h[i] + l[i]);
            if (!s_r && !p_r) exp_q.push_back(l[i] + h[i + 1]);
        end
        if (s_r && !p_r) exp_q.push_back(h[NSEG]);
        mon_tag = tag;
        mon_en = 1'b1;
        rd_strobe = 1'b1;
        seg(1'b0, 5);
        for (int i = 0; i < NSEG; i++) begin
            seg(1'b1, h[i]);
            seg(1'b0, l[i]);
        end
        seg(1'b1, h[NSEG]);
        seg(1'b0, 10);
        mon_en = 1'b0;
        rd_strobe = 1'b0;
        chk(exp_q.size() == 0, {tag, " all results"}, exp_q.size(), 0);
        exp_q.delete();
    endtask

    initial begin
        void'($urandom(32'd4711));
        do_reset();
        @(negedge clk);
        // R1: reset state
        chk(result_q == 0, "R1 result_q", int'(result_q), 0);
        chk(result_vld == 0, "R1 result_vld", int'(result_vld), 0);
        chk(fresh == 0, "R1 fresh", int'(fresh), 0);
        chk(overrun == 0, "R1 overrun", int'(overrun), 0);
        chk(overflow == 0, "R1 overflow", int'(overflow), 0);

        // R5: latency of a high-width capture
        seg(1'b0, 5);
        @(negedge clk);
        sig_in = 1'b1;
        repeat (10) @(negedge clk);
        sig_in = 1'b0;
        @(posedge clk);
        @(posedge clk);
        #1 chk(result_vld == 0, "R5 not before third edge", int'(result_vld), 0);
        @(posedge clk);
        #1 chk(result_vld == 1, "R5 third edge", int'(result_vld), 1);
        chk(result_q == 10, "R3 high width", int'(result_q), 10);
        @(posedge clk);
        #1 chk(result_vld == 0, "R5 single cycle", int'(result_vld), 0);
        chk(fresh == 1, "R6 fresh set", int'(fresh), 1);
        chk(overrun == 0, "R7 no overrun yet", int'(overrun), 0);

        // R7: second capture without a read
        seg(1'b0, 5);
        seg(1'b1, 6);
        seg(1'b0, 8);
        chk(overrun == 1, "R7 overrun set", int'(overrun), 1);
        chk(result_q == 6, "R3 second width", int'(result_q), 6);
        rd_pulse();
        chk(fresh == 0, "R6 fresh cleared", int'(fresh), 0);
        chk(overrun == 0, "R7 overrun cleared", int'(overrun), 0);

        // R8: interval beyond the counter range
        seg(1'b1, CMAX + 20);
        seg(1'b0, 10);
        chk(overflow == 1, "R8 overflow set", int'(overflow), 1);
        chk(result_q == 6, "R8 result kept", int'(result_q), 6);
        chk(fresh == 0, "R8 no fresh", int'(fresh), 0);
        rd_pulse();
        chk(overflow == 0, "R8 overflow cleared", int'(overflow), 0);
        seg(1'b1, CMAX);
        seg(1'b0, 10);
        chk(result_q == CMAX, "R8 exact maximum", int'(result_q), CMAX);
        chk(overflow == 0, "R8 no overflow at maximum", int'(overflow), 0);
        seg(1'b1, CMAX + 1);
        seg(1'b0, 10);
        chk(overflow == 1, "R8 one past maximum", int'(overflow), 1);
        chk(result_q == CMAX, "R8 result kept again", int'(result_q), CMAX);
        rd_pulse();

        // R3: shortest interval
        seg(1'b1, 2);
        seg(1'b0, 10);
        chk(result_q == 2, "R3 minimum width", int'(result_q), 2);
        rd_pulse();

        // R2/R4: random trains in all four modes
        for (int r = 0; r < 2; r++) begin
            rand_train(1'b1, 1'b0, "R2 high width");
            rand_train(1'b0, 1'b1, "R2 low width");
            rand_train(1'b1, 1'b1, "R4 rising period");
            rand_train(1'b0, 1'b0, "R4 falling period");
        end

        finish_run();
    end

endmodule